// File: doc/BRIEF.md
# Depth-Chained FIFO Slice

This block is one segment of a FIFO that is made deeper by placing several identical segments in a ring. Each segment has its own storage of `DEPTH` words. It also keeps two ownership tokens: a write token and a read token. Only the segment that holds the write token accepts incoming words, and only the segment that holds the read token presents outgoing words. Within a ring, at most one segment holds each token at any time. The whole ring therefore behaves like a single FIFO of `N*DEPTH` words.

The tokens move between segments as single-cycle pulses on a one-wire link. Each segment drives `xo`, and that signal feeds `xi` of the next segment. The last segment's `xo` wraps back to the first segment. Because one wire carries both kinds of hand-off, the receiving segment tells them apart by their order: write, read, write, read. This order is guaranteed because a segment can only hand off its read token after it has handed off its write token in the same lap.

A strapping input marks the one segment that owns both tokens when reset ends. Both data sides use a valid/ready handshake:
- **Write side.** A word enters a segment at a rising clock edge when `wr_valid` and `full_n` are both high.
- **Read side.** A word leaves a segment at a rising clock edge when `empty_n` and `rd_ready` are both high.
- **Flag rules.** `full_n` and `empty_n` never depend on `wr_valid` or `rd_ready` in the same cycle. A producer or consumer may raise or drop its own signal freely.

Around the ring, the same `wr_valid`, `wr_data` and `rd_ready` go to every segment. The combined write-ready is the OR of all `full_n` outputs, and the combined read-valid is the OR of all `empty_n` outputs. The outgoing word is taken from the segment whose `empty_n` is high.

Top module: `fifo_chain_slice`

## Requirements
- R1: While `rst_n` is low, every segment drives `full_n` high, `empty_n` low and `xo` low, and both pointers return to location 0. In the first cycle after reset, only the segment with `first_load_n` low shows `full_n` high. All other segments show `full_n` low and `empty_n` low.
- R2: `full_n` is high exactly when the segment holds the write token and stores fewer than `DEPTH` words. A word is stored at each rising edge where `wr_valid` and `full_n` are both high.
- R3: `empty_n` is high exactly when the segment holds the read token and stores at least one word. `rd_data` shows the oldest stored word, which is removed at a rising edge where `rd_ready` and `empty_n` are both high. While `empty_n` is high and `rd_ready` is low, `empty_n` and `rd_data` stay unchanged.
- R4: A write into the last physical location (`DEPTH-1`) releases the write token at that edge. The same write makes `xo` high for the one following cycle.
- R5: A read from the last physical location (`DEPTH-1`) releases the read token at that edge. The same read makes `xo` high for the one following cycle.
- R6: The segment decodes pulses on `xi` in alternating order, starting with a write hand-off after reset. A segment takes a token at the rising edge that ends the `xi` cycle. As a result, the combined ready or valid is low for exactly one cycle at each hand-off.
- R7: A segment that lacks the matching token stores nothing and removes nothing, whatever `wr_valid` and `rd_ready` do.
- R8: Across a ring, the combined active-low full flag is asserted only when every segment's `full_n` is low, and likewise for `empty_n`. These combined flags track the token-holding segment alone.
- R9: When the ring holds `N*DEPTH` words, the segment that holds the write token is full. `full_n` is then low on every segment, and further writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| first_load_n | input | 1 | Low marks the segment that owns both tokens after reset |
| wr_valid | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full_n | output | 1 | Write ready; low means full or no write token |
| rd_ready | input | 1 | Read request |
| rd_data | output | WIDTH | Oldest stored word |
| empty_n | output | 1 | Read valid; low means empty or no read token |
| xi | input | 1 | Token hand-off pulses from the previous segment |
| xo | output | 1 | Token hand-off pulses to the next segment |

## Verification
The bench builds a ring of three segments, each with `DEPTH=4` and `WIDTH=9`. A shallow store of four words lets both tokens travel the full ring many times within a few hundred cycles. It also lets the ring fill to its twelve-word limit and drain back to empty. The small depth also produces back-to-back accesses to the last physical location, so that a read hand-off and the next write hand-off from the same segment fall in adjacent cycles.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic {
    HAND_WR = 1'b0,
    HAND_RD = 1'b1
  } hand_kind_e;
endpackage

// File: rtl/fcs_ring_ptr.sv
module fcs_ring_ptr #(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          at_last
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  assign at_last = (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= '0;
    else if (adv) begin
      if (at_last)     ptr <= '0;
      else             ptr <= ptr + 1'b1;
    end
  end

  // R1
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

// File: rtl/fcs_store.sv
module fcs_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty,
  output logic             wr_at_last,
  output logic             rd_at_last
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;

  fcs_ring_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_en), .ptr(wptr), .at_last(wr_at_last)
  );

  fcs_ring_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_en), .ptr(rptr), .at_last(rd_at_last)
  );

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else begin
      unique case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == CAP);
  assign empty = (count == '0);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
endmodule

// File: rtl/fcs_token.sv
module fcs_token
  import fcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic first_load_n,
  input  logic xi,
  input  logic wr_last_done,
  input  logic rd_last_done,
  output logic wtok,
  output logic rtok,
  output logic xo
);
  hand_kind_e next_kind;
  logic       take_wr, take_rd;

  assign take_wr = xi && (next_kind == HAND_WR);
  assign take_rd = xi && (next_kind == HAND_RD);

  always_ff @(posedge clk) begin
    if (!rst_n)  next_kind <= HAND_WR;
    else if (xi) next_kind <= (next_kind == HAND_WR) ? HAND_RD : HAND_WR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            wtok <= ~first_load_n;
    else if (take_wr)      wtok <= 1'b1;
    else if (wr_last_done) wtok <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            rtok <= ~first_load_n;
    else if (take_rd)      rtok <= 1'b1;
    else if (rd_last_done) rtok <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) xo <= 1'b0;
    else        xo <= wr_last_done | rd_last_done;
  end

  // R6
  wtok_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wtok) |-> ($past(xi) && $past(next_kind) == HAND_WR));
  // R6
  rtok_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtok) |-> ($past(xi) && $past(next_kind) == HAND_RD));
  // R4
  wtok_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wtok) |-> xo);
  // R5
  rtok_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtok) |-> xo);
endmodule

// File: rtl/fifo_chain_slice.sv
module fifo_chain_slice #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full_n,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n,
  input  logic             xi,
  output logic             xo
);
  logic wtok, rtok;
  logic st_full, st_empty;
  logic wr_at_last, rd_at_last;
  logic wr_en, rd_en;

  assign full_n  = !rst_n || (wtok && !st_full);
  assign empty_n = rst_n && rtok && !st_empty;
  assign wr_en   = rst_n && wr_valid && wtok && !st_full;
  assign rd_en   = rd_ready && empty_n;

  fcs_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data),
    .full(st_full), .empty(st_empty),
    .wr_at_last(wr_at_last), .rd_at_last(rd_at_last)
  );

  fcs_token u_token (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .xi(xi),
    .wr_last_done(wr_en && wr_at_last),
    .rd_last_done(rd_en && rd_at_last),
    .wtok(wtok), .rtok(rtok), .xo(xo)
  );

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n && !rd_ready) |=> (empty_n && $stable(rd_data)));
  // R7
  no_token_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wtok && !xi) |=> !full_n);
endmodule

// File: tb/sim_fifo_chain_slice.sv
module sim_fifo_chain_slice;
  localparam int D = 4;
  localparam int W = 9;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic rd_ready = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [NS-1:0] full_n_v, empty_n_v, xo_v;
  logic [W-1:0] rdd0, rdd1, rdd2, comp_data;

  always #5 clk = ~clk;

  fifo_chain_slice #(.DEPTH(D), .WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b0),
    .wr_valid(wr_valid), .wr_data(wr_data), .full_n(full_n_v[0]),
    .rd_ready(rd_ready), .rd_data(rdd0), .empty_n(empty_n_v[0]),
    .xi(xo_v[2]), .xo(xo_v[0]));
  fifo_chain_slice #(.DEPTH(D), .WIDTH(W)) u1 (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b1),
    .wr_valid(wr_valid), .wr_data(wr_data), .full_n(full_n_v[1]),
    .rd_ready(rd_ready), .rd_data(rdd1), .empty_n(empty_n_v[1]),
    .xi(xo_v[0]), .xo(xo_v[1]));
  fifo_chain_slice #(.DEPTH(D), .WIDTH(W)) u2 (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b1),
    .wr_valid(wr_valid), .wr_data(wr_data), .full_n(full_n_v[2]),
    .rd_ready(rd_ready), .rd_data(rdd2), .empty_n(empty_n_v[2]),
    .xi(xo_v[1]), .xo(xo_v[2]));

  always_comb begin
    comp_data = '0;
    if (empty_n_v[0]) comp_data = comp_data | rdd0;
    if (empty_n_v[1]) comp_data = comp_data | rdd1;
    if (empty_n_v[2]) comp_data = comp_data | rdd2;
  end

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int q[$];
  int occ[NS];
  int xo_exp[NS];
  int xo_why[NS];
  int ws, wp, rs, rp;
  bit wgap, rgap;
  int next_word = 1;
  int dut_reads = 0;
  bit [15:0] lf = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit any_r, any_v;
    any_r = 1'b0;
    any_v = 1'b0;
    for (int k = 0; k < NS; k++) begin
      bit ef, ee;
      ef = (k == ws) && !wgap && (occ[k] < D);
      ee = (k == rs) && !rgap && (occ[k] > 0);
      any_r |= ef;
      any_v |= ee;
      if (wgap)                          chk("R6", full_n_v[k], ef);
      else if (k == ws && occ[k] == D)   chk("R9", full_n_v[k], ef);
      else                               chk("R2", full_n_v[k], ef);
      if (rgap) chk("R6", empty_n_v[k], ee);
      else      chk("R3", empty_n_v[k], ee);
      if (xo_why[k] == 2) chk("R5", xo_v[k], xo_exp[k]);
      else                chk("R4", xo_v[k], xo_exp[k]);
    end
    chk("R8", |full_n_v, any_r);
    chk("R8", |empty_n_v, any_v);
    if (any_v && q.size() > 0) chk("R3", comp_data, q[0]);
  endtask

  task automatic step(input bit wv, input bit rr);
    bit wf, rf;
    check_all();
    if ((|empty_n_v) && rr) dut_reads++;
    wr_valid = wv;
    rd_ready = rr;
    wr_data  = W'(next_word);
    wf = wv && !wgap && (occ[ws] < D);
    rf = rr && !rgap && (occ[rs] > 0);
    for (int k = 0; k < NS; k++) begin
      xo_exp[k] = 0;
      xo_why[k] = 0;
    end
    wgap = 1'b0;
    rgap = 1'b0;
    if (wf) begin
      q.push_back(next_word);
      next_word = (next_word + 37) % 512;
      occ[ws]++;
      if (wp == D - 1) begin
        xo_exp[ws] = 1; xo_why[ws] = 1; wgap = 1'b1;
        ws = (ws + 1) % NS; wp = 0;
      end else wp++;
    end
    if (rf) begin
      void'(q.pop_front());
      occ[rs]--;
      if (rp == D - 1) begin
        xo_exp[rs] = 1; xo_why[rs] = 2; rgap = 1'b1;
        rs = (rs + 1) % NS; rp = 0;
      end else rp++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NS; k++) begin
      occ[k] = 0; xo_exp[k] = 0; xo_why[k] = 0;
    end
    ws = 0; wp = 0; rs = 0; rp = 0; wgap = 0; rgap = 0;

    // R1: flags while reset is held
    repeat (3) @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      chk("R1", full_n_v[k], 1);
      chk("R1", empty_n_v[k], 0);
      chk("R1", xo_v[k], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1: only the first-load segment is ready after reset
    chk("R1", full_n_v, 3'b001);
    chk("R1", empty_n_v, 3'b000);

    // fill past capacity, R9 and R6 gaps covered in step
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    chk("R9", |full_n_v, 0);
    chk("R9", q.size(), NS * D);

    // drain past empty; R7: the writes offered while full were not stored
    dut_reads = 0;
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    chk("R7", dut_reads, NS * D);
    chk("R7", |empty_n_v, 0);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[3], lf[1] & (lf[5] | lf[7]));
    end
    for (int i = 0; i < 300; i++) step(1'b1, i[0]);
    for (int i = 0; i < 60; i++) step(1'b0, 1'b1);
    chk("R7", |empty_n_v, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule